// File: doc/BRIEF.md
# Descriptor-List Stream DMA Walker

This block is the DMA engine for one audio stream. It reads a buffer descriptor list from memory into local registers, then serves transfer requests from the codec side. For each request it splits the requested byte count into memory bursts. Each burst is limited by the space left in the cyclic buffer and by the bytes left in the current descriptor. The engine keeps a link position inside the cyclic buffer and walks the descriptors in a ring. It can write the link position to a position buffer in memory, and it raises a completion status bit when a descriptor marked for interrupt is finished.

A stream is configured through a 32-bit control word and a few configuration inputs: the list base address, the last valid index and the cyclic buffer length. When the run bit goes from 0 to 1, the engine loads the list and resets its walk state. The fixed stream index parameter sets the direction. Low streams capture audio and write memory. High streams play audio and read memory. The audio bytes themselves travel on an external FIFO path. This block issues the memory commands (address, length, direction) that steer that path.

Top module: `bdl_stream_walker`

## Requirements
- R1: After reset the control word reads 0, `xfer_ready` is 1 and no memory command is issued.
- R2: When the run bit (control bit 1) goes from 0 to 1, the engine fetches last index + 1 descriptors. It reads each one as four 4-byte memory reads at list base + 16·i + 4·w, for w = 0..3 in order. The words are: address low, address high, byte length, flags. Flags bit 0 marks interrupt on completion.
- R3: Each burst is min(bytes still requested, cyclic length − link position, descriptor length − offset). A burst of zero bytes issues no memory command.
- R4: A data burst goes to descriptor address + offset. Its direction is memory write when the stream index is below 4 and memory read otherwise. The burst length is added to both the link position and the offset.
- R5: When the offset reaches the descriptor length, the offset returns to 0 and the next descriptor is used. After the last descriptor, the index wraps to 0 and the link position returns to 0.
- R6: If any descriptor completed during a request has its interrupt flag set, control bit 26 is set when the request finishes. A control write with bit 26 = 1 clears it.
- R7: When position-base bit 0 is 1, each served request ends with one 4-byte memory write of the link position. The write goes to (position base with bit 0 cleared) + 8·stream index.
- R8: A request while the run bit is 0, or before a list has been loaded since the last stream reset, completes with 0 bytes moved and no memory command.
- R9: One request performs at most last index + 1 burst steps, so it never walks the list more than once.
- R10: A control write with bit 0 = 1 forces the control word to 0x2000_0001 (FIFO ready in bit 29, reset held in bit 0) and discards the loaded list.
- R11: A control write with bit 0 = 0 loads bits 23:0 of the written value: run in bit 1 and the stream number in bits 23:20. Bit 29 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_rd | output | 32 | Current control and status word |
| bdl_base | input | AW | Descriptor list base address |
| last_idx | input | 8 | Index of the last valid descriptor |
| ring_len | input | LW | Cyclic buffer length in bytes |
| pos_base | input | AW | Position buffer base; bit 0 enables write-back |
| xfer_req | input | 1 | Transfer request, accepted when `xfer_ready` is 1 |
| xfer_len | input | LW | Requested byte count |
| xfer_ready | output | 1 | Engine idle and able to accept a request |
| xfer_done | output | 1 | One-cycle pulse at the end of a request |
| xfer_moved | output | LW | Bytes moved, valid with `xfer_done` |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted (read data valid) |
| mem_kind | output | 2 | 0 descriptor fetch, 1 data burst, 2 position write |
| mem_write | output | 1 | 1 for a memory write |
| mem_addr | output | AW | Command byte address |
| mem_len | output | LW | Command byte count |
| mem_wdata | output | 32 | Data for a position write |
| mem_rdata | input | 32 | Read data for a descriptor fetch |

## Verification
Requests are tried in four shapes. A request that ends inside one descriptor tests the offset clamp alone. A request that crosses a descriptor boundary tests the hand-over of offset and index. A request that passes the end of the list tests the wrap of the index and the link position, and the completion bit from a flagged descriptor. An oversized request tests the one-pass limit. A second configuration uses a cyclic length shorter than the descriptor total, so the cyclic clamp wins and a zero-byte step occurs, with position write-back turned off. Requests made before start, after a stream reset and after stop separate the zero-byte path from the walking path.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   typedef enum logic [1:0] {
      MK_FETCH = 2'd0,
      MK_DATA  = 2'd1,
      MK_POS   = 2'd2
   } mem_kind_e;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_FETCH,
      WS_CALC,
      WS_MEM,
      WS_UPD,
      WS_POS,
      WS_DONE
   } walk_state_e;

   localparam int CTL_RST_BIT  = 0;
   localparam int CTL_RUN_BIT  = 1;
   localparam int STS_IOC_BIT  = 26;
   localparam int STS_FIFO_BIT = 29;
   localparam int IN_STREAMS   = 4;
   localparam logic [31:0] CTL_RESET_WORD = 32'h2000_0001;
endpackage

// File: rtl/sdw_desc_store.sv
module sdw_desc_store #(
   parameter int AW    = 64,
   parameter int LW    = 32,
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [1:0]    wr_word,
   input  logic [31:0]   wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_addr,
   output logic [LW-1:0] rd_len,
   output logic          rd_ioc
);
   logic [63:0]   addr_q [DEPTH];
   logic [LW-1:0] len_q  [DEPTH];
   logic          ioc_q  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IW'(e)) begin
            case (wr_word)
               2'd0: addr_q[e][31:0]  <= wr_data;
               2'd1: addr_q[e][63:32] <= wr_data;
               2'd2: len_q[e]         <= wr_data[LW-1:0];
               default: ioc_q[e]      <= wr_data[0];
            endcase
         end
      end
   end

   assign rd_addr = addr_q[rd_idx][AW-1:0];
   assign rd_len  = len_q[rd_idx];
   assign rd_ioc  = ioc_q[rd_idx];
endmodule

// File: rtl/sdw_chunk_clamp.sv
module sdw_chunk_clamp #(
   parameter int LW = 32
) (
   input  logic [LW-1:0] want,
   input  logic [LW-1:0] ring_size,
   input  logic [LW-1:0] ring_pos,
   input  logic [LW-1:0] desc_len,
   input  logic [LW-1:0] desc_off,
   output logic [LW-1:0] chunk
);
   logic [LW-1:0] ring_room;
   logic [LW-1:0] desc_room;
   logic [LW-1:0] first_min;

   always_comb begin
      ring_room = (ring_size > ring_pos) ? ring_size - ring_pos : '0;
      desc_room = (desc_len > desc_off) ? desc_len - desc_off : '0;
      first_min = (want < ring_room) ? want : ring_room;
      chunk     = (first_min < desc_room) ? first_min : desc_room;
   end
endmodule

// File: rtl/bdl_stream_walker.sv
module bdl_stream_walker
   import sdw_pkg::*;
#(
   parameter int AW         = 64,
   parameter int LW         = 32,
   parameter int DEPTH      = 8,
   parameter int STREAM_IDX = 5,
   localparam int IW        = $clog2(DEPTH),
   localparam int NW        = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr_en,
   input  logic [31:0]   ctl_wr_data,
   output logic [31:0]   ctl_rd,
   input  logic [AW-1:0] bdl_base,
   input  logic [7:0]    last_idx,
   input  logic [LW-1:0] ring_len,
   input  logic [AW-1:0] pos_base,
   input  logic          xfer_req,
   input  logic [LW-1:0] xfer_len,
   output logic          xfer_ready,
   output logic          xfer_done,
   output logic [LW-1:0] xfer_moved,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [1:0]    mem_kind,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [LW-1:0] mem_len,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);
   initial begin
      if (DEPTH < 2 || DEPTH > 256) $error("DEPTH must lie in 2..256");
      if (AW <= 32 || AW > 64) $error("AW must lie in 33..64");
      if (LW < 8 || LW > 32) $error("LW must lie in 8..32");
      if (STREAM_IDX < 0 || STREAM_IDX > 7) $error("STREAM_IDX must lie in 0..7");
   end

   walk_state_e   state_q;
   logic [31:0]   ctl_q;
   logic          pend_start_q;
   logic          parsed_q;
   logic [NW-1:0] nent_q;
   logic [IW-1:0] fidx_q;
   logic [1:0]    fword_q;
   logic [IW-1:0] be_q;
   logic [LW-1:0] bp_q;
   logic [LW-1:0] lpib_q;
   logic [LW-1:0] bsize_q;
   logic [LW-1:0] left_q;
   logic [LW-1:0] moved_q;
   logic [NW-1:0] iter_q;
   logic          ioc_hit_q;
   logic [LW-1:0] chunk_q;

   logic [AW-1:0] d_addr;
   logic [LW-1:0] d_len;
   logic          d_ioc;
   logic [LW-1:0] chunk_c;
   logic [8:0]    lvi_p1;
   logic [NW-1:0] nent_c;
   logic          data_write;
   logic          pos_en;
   logic          fetch_last;
   logic          list_last;
   logic [LW-1:0] bp_next;

   // Direction is fixed by the stream index
   if (STREAM_IDX < IN_STREAMS) begin : g_capture
      assign data_write = 1'b1;
   end else begin : g_playback
      assign data_write = 1'b0;
   end

   sdw_desc_store #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (state_q == WS_FETCH && mem_ready),
      .wr_idx  (fidx_q),
      .wr_word (fword_q),
      .wr_data (mem_rdata),
      .rd_idx  (be_q),
      .rd_addr (d_addr),
      .rd_len  (d_len),
      .rd_ioc  (d_ioc)
   );

   sdw_chunk_clamp #(.LW(LW)) u_clamp (
      .want      (left_q),
      .ring_size (bsize_q),
      .ring_pos  (lpib_q),
      .desc_len  (d_len),
      .desc_off  (bp_q),
      .chunk     (chunk_c)
   );

   always_comb begin
      lvi_p1     = {1'b0, last_idx} + 9'd1;
      nent_c     = (lvi_p1 > 9'(DEPTH)) ? NW'(DEPTH) : NW'(lvi_p1);
      pos_en     = pos_base[0];
      fetch_last = ({1'b0, fidx_q} == nent_q - NW'(1)) && (fword_q == 2'd3);
      list_last  = ({1'b0, be_q} == nent_q - NW'(1));
      bp_next    = bp_q + chunk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= WS_IDLE;
         ctl_q        <= '0;
         pend_start_q <= 1'b0;
         parsed_q     <= 1'b0;
         nent_q       <= '0;
         fidx_q       <= '0;
         fword_q      <= '0;
         be_q         <= '0;
         bp_q         <= '0;
         lpib_q       <= '0;
         bsize_q      <= '0;
         left_q       <= '0;
         moved_q      <= '0;
         iter_q       <= '0;
         ioc_hit_q    <= 1'b0;
         chunk_q      <= '0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (pend_start_q) begin
                  pend_start_q <= 1'b0;
                  parsed_q     <= 1'b0;
                  nent_q       <= nent_c;
                  bsize_q      <= ring_len;
                  lpib_q       <= '0;
                  be_q         <= '0;
                  bp_q         <= '0;
                  fidx_q       <= '0;
                  fword_q      <= '0;
                  state_q      <= WS_FETCH;
               end else if (xfer_req) begin
                  moved_q   <= '0;
                  ioc_hit_q <= 1'b0;
                  left_q    <= xfer_len;
                  iter_q    <= '0;
                  state_q   <= (ctl_q[CTL_RUN_BIT] && parsed_q) ? WS_CALC : WS_DONE;
               end
            end
            WS_FETCH: begin
               if (mem_ready) begin
                  fword_q <= fword_q + 2'd1;
                  if (fword_q == 2'd3) fidx_q <= fidx_q + IW'(1);
                  if (fetch_last) begin
                     parsed_q <= ctl_q[CTL_RUN_BIT];
                     state_q  <= WS_IDLE;
                  end
               end
            end
            WS_CALC: begin
               if (left_q == '0 || iter_q == nent_q) begin
                  state_q <= pos_en ? WS_POS : WS_DONE;
               end else begin
                  chunk_q <= chunk_c;
                  state_q <= (chunk_c != '0) ? WS_MEM : WS_UPD;
               end
            end
            WS_MEM: begin
               if (mem_ready) state_q <= WS_UPD;
            end
            WS_UPD: begin
               left_q  <= left_q - chunk_q;
               moved_q <= moved_q + chunk_q;
               iter_q  <= iter_q + NW'(1);
               if (bp_next == d_len) begin
                  bp_q <= '0;
                  if (d_ioc) ioc_hit_q <= 1'b1;
                  if (list_last) begin
                     be_q   <= '0;
                     lpib_q <= '0;
                  end else begin
                     be_q   <= be_q + IW'(1);
                     lpib_q <= lpib_q + chunk_q;
                  end
               end else begin
                  bp_q   <= bp_next;
                  lpib_q <= lpib_q + chunk_q;
               end
               state_q <= WS_CALC;
            end
            WS_POS: begin
               if (mem_ready) state_q <= WS_DONE;
            end
            WS_DONE: begin
               if (ioc_hit_q) ctl_q[STS_IOC_BIT] <= 1'b1;
               state_q <= WS_IDLE;
            end
            default: state_q <= WS_IDLE;
         endcase

         // Control writes come last so that they take priority
         if (ctl_wr_en) begin
            if (ctl_wr_data[CTL_RST_BIT]) begin
               ctl_q        <= CTL_RESET_WORD;
               pend_start_q <= 1'b0;
               parsed_q     <= 1'b0;
            end else begin
               ctl_q[23:0] <= ctl_wr_data[23:0];
               if (ctl_wr_data[STS_IOC_BIT]) ctl_q[STS_IOC_BIT] <= 1'b0;
               if (!ctl_q[CTL_RUN_BIT] && ctl_wr_data[CTL_RUN_BIT]) pend_start_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      mem_valid = 1'b0;
      mem_kind  = MK_FETCH;
      mem_write = 1'b0;
      mem_addr  = '0;
      mem_len   = '0;
      mem_wdata = '0;
      case (state_q)
         WS_FETCH: begin
            mem_valid = 1'b1;
            mem_kind  = MK_FETCH;
            mem_addr  = bdl_base + AW'({fidx_q, fword_q, 2'b00});
            mem_len   = LW'(4);
         end
         WS_MEM: begin
            mem_valid = 1'b1;
            mem_kind  = MK_DATA;
            mem_write = data_write;
            mem_addr  = d_addr + AW'(bp_q);
            mem_len   = chunk_q;
         end
         WS_POS: begin
            mem_valid = 1'b1;
            mem_kind  = MK_POS;
            mem_write = 1'b1;
            mem_addr  = {pos_base[AW-1:1], 1'b0} + AW'(STREAM_IDX * 8);
            mem_len   = LW'(4);
            mem_wdata = 32'(lpib_q);
         end
         default: ;
      endcase
   end

   assign ctl_rd     = ctl_q;
   assign xfer_ready = (state_q == WS_IDLE) && !pend_start_q;
   assign xfer_done  = (state_q == WS_DONE);
   assign xfer_moved = moved_q;
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
   parameter int AW         = 64,
   parameter int LW         = 32,
   parameter int STREAM_IDX = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_wr_en,
   input logic [31:0]   ctl_wr_data,
   input logic [31:0]   ctl_rd,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [1:0]    mem_kind,
   input logic          mem_write,
   input logic [AW-1:0] mem_addr,
   input logic [LW-1:0] mem_len,
   input logic [AW-1:0] pos_base,
   input logic          xfer_done,
   input logic          xfer_ready
);
   // R2: descriptor fetches are 4-byte reads
   a_r2_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == 2'd0) |-> (!mem_write && mem_len == LW'(4)));

   // R3: a zero-byte step never reaches the memory port
   a_r3_no_empty_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == 2'd1) |-> (mem_len != '0));

   // R4: data direction follows the stream index
   a_r4_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == 2'd1) |-> (mem_write == (STREAM_IDX < 4)));

   // R7: position write lands in the stream's slot
   a_r7_pos_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == 2'd2) |->
         (mem_write && mem_len == LW'(4) && mem_addr[2:0] == 3'b000 && pos_base[0]));

   // R10: stream reset forces the fixed control word
   a_r10_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_en && ctl_wr_data[0]) |=> (ctl_rd == 32'h2000_0001));

   // R1: a pending command holds until accepted
   a_r1_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_kind)));

   // R8: completion is a single-cycle pulse outside the idle state
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!xfer_ready && !mem_valid));
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);
endmodule

bind bdl_stream_walker sdw_checker #(.AW(AW), .LW(LW), .STREAM_IDX(STREAM_IDX)) u_sdw_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr_en   (ctl_wr_en),
   .ctl_wr_data (ctl_wr_data),
   .ctl_rd      (ctl_rd),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_kind    (mem_kind),
   .mem_write   (mem_write),
   .mem_addr    (mem_addr),
   .mem_len     (mem_len),
   .pos_base    (pos_base),
   .xfer_done   (xfer_done),
   .xfer_ready  (xfer_ready)
);

// File: tb/test_bdl_stream_walker.sv
module test_bdl_stream_walker;
   localparam int AW = 64;
   localparam int LW = 32;

   typedef struct {
      logic [1:0]    kind;
      logic          wr;
      logic [AW-1:0] addr;
      logic [LW-1:0] len;
      logic [31:0]   wdata;
      string         tag;
   } cmd_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr_en = 1'b0;
   logic [31:0]   ctl_wr_data = '0;
   logic [31:0]   ctl_rd;
   logic [AW-1:0] bdl_base = 64'h8000;
   logic [7:0]    last_idx = 8'd2;
   logic [LW-1:0] ring_len = 32'd144;
   logic [AW-1:0] pos_base = 64'h9001;
   logic          xfer_req = 1'b0;
   logic [LW-1:0] xfer_len = '0;
   logic          xfer_ready;
   logic          xfer_done;
   logic [LW-1:0] xfer_moved;
   logic          mem_valid;
   logic          mem_ready = 1'b0;
   logic [1:0]    mem_kind;
   logic          mem_write;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_len;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   cmd_t exp_q[$];

   logic [31:0] tbl_addr [3] = '{32'h1000, 32'h2000, 32'h3000};
   logic [31:0] tbl_len  [3] = '{32'd64, 32'd32, 32'd48};
   logic [31:0] tbl_flag [3] = '{32'd0, 32'd1, 32'd0};

   always #4 clk = ~clk;

   bdl_stream_walker #(.AW(AW), .LW(LW), .DEPTH(8), .STREAM_IDX(5)) i_bdl_stream_walker (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .ctl_rd(ctl_rd), .bdl_base(bdl_base), .last_idx(last_idx), .ring_len(ring_len),
      .pos_base(pos_base), .xfer_req(xfer_req), .xfer_len(xfer_len),
      .xfer_ready(xfer_ready), .xfer_done(xfer_done), .xfer_moved(xfer_moved),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_len(mem_len),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic w, input logic [AW-1:0] a,
                       input logic [LW-1:0] l, input logic [31:0] d, input string tag);
      cmd_t c;
      c.kind = k; c.wr = w; c.addr = a; c.len = l; c.wdata = d; c.tag = tag;
      exp_q.push_back(c);
   endtask

   task automatic push_fetches(input int n);
      for (int i = 0; i < n; i++)
         for (int w = 0; w < 4; w++)
            push(2'd0, 1'b0, 64'h8000 + 64'(16 * i + 4 * w), 32'd4, 32'd0, "R2");
   endtask

   function automatic logic [31:0] fetch_word(input logic [AW-1:0] a);
      int idx;
      int w;
      idx = int'((a - 64'h8000) >> 4);
      w   = int'(a[3:2]);
      if (idx < 0 || idx > 2) return 32'd0;
      case (w)
         0: return tbl_addr[idx];
         1: return 32'd0;
         2: return tbl_len[idx];
         default: return tbl_flag[idx];
      endcase
   endfunction

   // Memory model and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_valid && !mem_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected memory command addr", mem_addr, 0);
            end else begin
               cmd_t e;
               e = exp_q.pop_front();
               check(mem_kind == e.kind, e.tag, "command kind", mem_kind, e.kind);
               check(mem_write == e.wr, e.tag, "command direction", mem_write, e.wr);
               check(mem_addr == e.addr, e.tag, "command address", mem_addr, e.addr);
               check(mem_len == e.len, e.tag, "command length", mem_len, e.len);
               if (e.kind == 2'd2)
                  check(mem_wdata == e.wdata, e.tag, "position value", mem_wdata, e.wdata);
            end
            mem_rdata = fetch_word(mem_addr);
            mem_ready = 1'b1;
         end else begin
            mem_ready = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         check(1'b0, "R1", "watchdog expired", cycles, 20000);
         report();
      end
   end

   task automatic wr_ctl(input logic [31:0] v);
      @(negedge clk);
      ctl_wr_en = 1'b1;
      ctl_wr_data = v;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   task automatic wait_ready();
      while (!xfer_ready) @(negedge clk);
   endtask

   task automatic do_xfer(input int len, input int exp_moved, input bit exp_ioc,
                          input string tag);
      wait_ready();
      xfer_req = 1'b1;
      xfer_len = LW'(len);
      @(negedge clk);
      xfer_req = 1'b0;
      while (!xfer_done) @(negedge clk);
      check(xfer_moved == LW'(exp_moved), tag, "bytes moved", xfer_moved, exp_moved);
      @(negedge clk);
      check(ctl_rd[26] == exp_ioc, "R6", "completion bit", ctl_rd[26], exp_ioc);
      check(exp_q.size() == 0, tag, "commands left in scoreboard", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(ctl_rd == 32'd0, "R1", "control word", ctl_rd, 0);
      check(xfer_ready == 1'b1, "R1", "ready", xfer_ready, 1);
      check(mem_valid == 1'b0, "R1", "memory idle", mem_valid, 0);

      // R8: request before any start moves nothing
      do_xfer(16, 0, 1'b0, "R8");

      // R2/R11: start, stream number 3
      push_fetches(3);
      wr_ctl(32'h0030_0002);
      wait_ready();
      check(exp_q.size() == 0, "R2", "fetches outstanding", exp_q.size(), 0);
      check(ctl_rd == 32'h0030_0002, "R11", "control word after start", ctl_rd, 32'h0030_0002);

      // R4: inside first descriptor
      push(2'd1, 1'b0, 64'h1000, 32'd40, 0, "R4");
      push(2'd2, 1'b1, 64'h9028, 32'd4, 32'd40, "R7");
      do_xfer(40, 40, 1'b0, "R4");

      // R5: crosses a descriptor boundary
      push(2'd1, 1'b0, 64'h1028, 32'd24, 0, "R3");
      push(2'd1, 1'b0, 64'h2000, 32'd16, 0, "R5");
      push(2'd2, 1'b1, 64'h9028, 32'd4, 32'd80, "R7");
      do_xfer(40, 40, 1'b0, "R5");

      // R5/R6: wrap through flagged descriptor
      push(2'd1, 1'b0, 64'h2010, 32'd16, 0, "R5");
      push(2'd1, 1'b0, 64'h3000, 32'd48, 0, "R5");
      push(2'd1, 1'b0, 64'h1000, 32'd36, 0, "R5");
      push(2'd2, 1'b1, 64'h9028, 32'd4, 32'd36, "R7");
      do_xfer(100, 100, 1'b1, "R5");

      // R6: clear completion bit
      wr_ctl(32'h0430_0002);
      check(ctl_rd == 32'h0030_0002, "R6", "control word after clear", ctl_rd, 32'h0030_0002);

      // R9: oversized request stops after one pass
      push(2'd1, 1'b0, 64'h1024, 32'd28, 0, "R9");
      push(2'd1, 1'b0, 64'h2000, 32'd32, 0, "R9");
      push(2'd1, 1'b0, 64'h3000, 32'd48, 0, "R9");
      push(2'd2, 1'b1, 64'h9028, 32'd4, 32'd0, "R7");
      do_xfer(1000, 108, 1'b1, "R9");

      // R10: stream reset
      wr_ctl(32'h0000_0001);
      check(ctl_rd == 32'h2000_0001, "R10", "control word after reset", ctl_rd, 32'h2000_0001);
      do_xfer(8, 0, 1'b0, "R10");

      // R11: release reset keeps FIFO-ready bit
      wr_ctl(32'h0430_0000);
      check(ctl_rd == 32'h2030_0000, "R11", "control word after release", ctl_rd, 32'h2030_0000);

      // R3: short cyclic buffer, no position write
      ring_len = 32'd100;
      pos_base = 64'h9000;
      push_fetches(3);
      wr_ctl(32'h0030_0002);
      wait_ready();
      check(exp_q.size() == 0, "R2", "refetch outstanding", exp_q.size(), 0);
      push(2'd1, 1'b0, 64'h1000, 32'd64, 0, "R3");
      push(2'd1, 1'b0, 64'h2000, 32'd26, 0, "R3");
      do_xfer(90, 90, 1'b0, "R3");
      push(2'd1, 1'b0, 64'h201A, 32'd6, 0, "R3");
      push(2'd1, 1'b0, 64'h3000, 32'd4, 0, "R3");
      do_xfer(20, 10, 1'b1, "R3");

      // R8: stopped stream moves nothing
      wr_ctl(32'h0430_0000);
      do_xfer(4, 0, 1'b0, "R8");

      report();
   end
endmodule